// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block buffers 18-bit words between two unrelated clock domains. The producer pushes words on the write clock through a valid/ready pair, and the consumer pops them on the read clock through a second valid/ready pair. Each pop loads a registered output word. Besides the two handshake flags, the block reports a half-full flag and two programmable early-warning flags. The early-warning flags fire a user-chosen number of words before the FIFO empties or fills.

Back-pressure works as follows. A word is taken on a write-clock edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverted full flag. A pop happens on a read-clock edge only when `rd_ready` and `rd_valid` are both high. `rd_valid` is the inverted empty flag. The popped word appears on `rd_data` after that edge and stays there until the next pop. A producer may hold `wr_valid` high while `wr_ready` is low, and a consumer may hold `rd_ready` high while `rd_valid` is low. Neither has any effect.

The two thresholds are loaded from the write side. The producer raises `load_en` together with `wr_valid`, and the low address-width bits of `wr_data` are captured as a threshold instead of being queued. Thresholds should only be reloaded while the FIFO is idle. `flag_mode` chooses where each early-warning flag is computed.

Top module: `dcfifo_pflags`

## Requirements
- R1: Words leave in the order they were accepted, with all 18 bits intact. `rd_data` changes only on a read-clock edge with `rd_valid` and `rd_ready` both high, and otherwise holds its value.
- R2: `rd_valid` is high only when at least one accepted word has not yet been popped. After a write into an idle FIFO it rises within four read-clock edges.
- R3: `wr_ready` is low whenever 2^ADDR_W words are stored. A write offered while `wr_ready` is low leaves both the queue and its contents unchanged.
- R4: A pop offered while `rd_valid` is low leaves `rd_data` and the read position unchanged.
- R5: `half_n` is low exactly when the stored count is greater than half of the depth.
- R6: `afull_n` is low when the stored count is at least the depth minus the full threshold m.
- R7: `aempty_n` is low when the stored count is less than or equal to the empty threshold n.
- R8: A write-clock edge with `wr_valid` and `load_en` both high stores `wr_data[ADDR_W-1:0]` into a threshold and queues nothing. The loads alternate between n and m, starting with n after reset. Both thresholds reset to 7.
- R9: When `flag_mode` is 0, each early-warning flag is computed in its own clock domain. When it is 1, each is computed in the opposite domain and passed back through two flops. Once the FIFO is idle, both modes settle to the same values.
- R10: The write and read positions cross between domains as Gray code. At most one bit changes per clock.
- R11: While `rst_n` is low, both positions clear. The flags then read `rd_valid`=0, `wr_ready`=1, `half_n`=1, `aempty_n`=0, `afull_n`=1, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| flag_mode | input | 1 | Early-warning flag timing: 0 = own domain, 1 = cross-domain |
| wr_valid | input | 1 | Producer offers a word (or a threshold when `load_en` is high) |
| wr_ready | output | 1 | FIFO can accept a word (inverted full flag) |
| load_en | input | 1 | Route the offered write into the threshold registers |
| wr_data | input | 18 | Word to queue, or threshold in the low ADDR_W bits |
| rd_ready | input | 1 | Consumer requests a pop |
| rd_valid | output | 1 | A word is available to pop (inverted empty flag) |
| rd_data | output | 18 | Registered output word |
| half_n | output | 1 | Low when more than half the depth is occupied |
| aempty_n | output | 1 | Low when the count is at or below threshold n |
| afull_n | output | 1 | Low when the count is at or above depth minus m |

## Verification
Several properties are checked on every cycle by the assertions:
- the Gray step of each position;
- the stored count never exceeding the depth on the write side;
- `rd_valid` never being high while the synchronized positions are equal;
- blocked writes and pops leaving the positions and the output word unchanged.

The threshold arithmetic for the half-full and early-warning flags can only be shown by the bench's scenarios. The same holds for the alternating threshold loads, the agreement of the two flag modes once idle, and the end-to-end word order under irregular read stalls. The bench checks these against a queue model and compares the output word on every read clock.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int unsigned DCF_WORD_W  = 18;
  localparam int unsigned DCF_OFF_RST = 7;
  localparam int unsigned DCF_G2B_W   = 16;

  typedef enum logic {
    FLAG_LOCAL = 1'b0,
    FLAG_CROSS = 1'b1
  } flag_mode_e;

  function automatic logic [DCF_G2B_W-1:0] gray_to_bin(input logic [DCF_G2B_W-1:0] g);
    logic [DCF_G2B_W-1:0] b;
    b[DCF_G2B_W-1] = g[DCF_G2B_W-1];
    for (int i = DCF_G2B_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 18,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 18,
  localparam int unsigned PW = AW + 1,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          load_en,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_ready,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          half_n,
  output logic          afull_loc_n,
  output logic          aempty_x_n,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx, cnt_cur;
  logic          ld, ld_sel;

  assign we      = wr_valid & wr_ready & ~load_en;
  assign ld      = wr_valid & load_en;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + PW'(we);
  assign rbin_s  = PW'(gray_to_bin(DCF_G2B_W'(rgray_s)));
  assign cnt_nx  = wbin_nx - rbin_s;
  assign cnt_cur = wbin - rbin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      wr_ready    <= 1'b1;
      half_n      <= 1'b1;
      afull_loc_n <= 1'b1;
      aempty_x_n  <= 1'b0;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= wbin_nx ^ (wbin_nx >> 1);
      wr_ready    <= (cnt_nx != PW'(DEPTH));
      half_n      <= !(cnt_nx > PW'(DEPTH / 2));
      afull_loc_n <= !(cnt_nx >= PW'(DEPTH) - {1'b0, af_off});
      aempty_x_n  <= !(cnt_nx <= {1'b0, ae_off});
    end
  end

  // threshold loading: n first, then m, alternating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sel <= 1'b0;
      ae_off <= AW'(DCF_OFF_RST);
      af_off <= AW'(DCF_OFF_RST);
    end else if (ld) begin
      ld_sel <= ~ld_sel;
      if (!ld_sel) ae_off <= wr_data[AW-1:0];
      else         af_off <= wr_data[AW-1:0];
    end
  end

  p_gray_step_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_cur <= PW'(DEPTH));

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wbin == $past(wbin)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 18,
  localparam int unsigned PW = AW + 1,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] ram_q,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic          rd_valid,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_data,
  output logic          aempty_loc_n,
  output logic          afull_x_n
);
  logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
  logic          pop;

  assign pop     = rd_ready & rd_valid;
  assign raddr   = rbin[AW-1:0];
  assign rbin_nx = rbin + PW'(pop);
  assign wbin_s  = PW'(gray_to_bin(DCF_G2B_W'(wgray_s)));
  assign cnt_nx  = wbin_s - rbin_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      rd_valid     <= 1'b0;
      aempty_loc_n <= 1'b0;
      afull_x_n    <= 1'b1;
    end else begin
      rbin         <= rbin_nx;
      rgray        <= rbin_nx ^ (rbin_nx >> 1);
      rd_valid     <= (cnt_nx != '0);
      aempty_loc_n <= !(cnt_nx <= {1'b0, ae_off});
      afull_x_n    <= !(cnt_nx >= PW'(DEPTH) - {1'b0, af_off});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (pop) rd_data <= ram_q;
  end

  p_gray_step_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (wbin_s != rbin));

  p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> ($stable(rd_data) && $stable(rbin)));
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = DCF_WORD_W,
  localparam int unsigned PW = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              flag_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              load_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr, ae_off, af_off;
  logic [DATA_W-1:0] ram_q;
  logic              we;
  logic              afull_loc_n, aempty_x_n, aempty_loc_n, afull_x_n;
  logic              aempty_x_s, afull_x_s;
  flag_mode_e        mode;

  assign mode = flag_mode_e'(flag_mode);

  dcf_wr_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .load_en(load_en),
    .wr_data(wr_data), .rgray_s(rgray_s), .wr_ready(wr_ready), .wgray(wgray),
    .waddr(waddr), .we(we), .half_n(half_n), .afull_loc_n(afull_loc_n),
    .aempty_x_n(aempty_x_n), .ae_off(ae_off), .af_off(af_off)
  );

  dcf_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_q)
  );

  dcf_rd_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_ready(rd_ready), .wgray_s(wgray_s),
    .ram_q(ram_q), .ae_off(ae_off), .af_off(af_off), .rd_valid(rd_valid),
    .rgray(rgray), .raddr(raddr), .rd_data(rd_data),
    .aempty_loc_n(aempty_loc_n), .afull_x_n(afull_x_n)
  );

  dcf_sync #(.W(PW), .RST_VAL('0)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_sync #(.W(PW), .RST_VAL('0)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_sync #(.W(1), .RST_VAL(1'b0)) u_ae_x (
    .clk(rd_clk), .rst_n(rst_n), .d(aempty_x_n), .q(aempty_x_s));

  dcf_sync #(.W(1), .RST_VAL(1'b1)) u_af_x (
    .clk(wr_clk), .rst_n(rst_n), .d(afull_x_n), .q(afull_x_s));

  assign aempty_n = (mode == FLAG_CROSS) ? aempty_x_s : aempty_loc_n;
  assign afull_n  = (mode == FLAG_CROSS) ? afull_x_s  : afull_loc_n;
endmodule

// File: tb/test_dcfifo_pflags.sv
module test_dcfifo_pflags;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic        flag_mode = 1'b0, wr_valid = 1'b0, load_en = 1'b0, rd_ready = 1'b0;
  logic [17:0] wr_data = '0;
  logic        wr_ready, rd_valid, half_n, aempty_n, afull_n;
  logic [17:0] rd_data;

  int n_chk = 0, n_err = 0;
  logic [17:0] q[$];
  logic [17:0] exp_rd = '0;
  logic [17:0] last_word;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  dcfifo_pflags #(.ADDR_W(AW)) i_dcfifo_pflags (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .flag_mode(flag_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .load_en(load_en), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: queue updated on accepted transfers
  always @(posedge wr_clk)
    if (rst_n && wr_valid && wr_ready && !load_en) q.push_back(wr_data);

  always @(posedge rd_clk)
    if (rst_n && rd_valid && rd_ready) exp_rd = q.pop_front();

  always @(negedge rd_clk) if (rst_n) begin
    chk(rd_data == exp_rd, "R1 rd_data per clock", 32'(rd_data), 32'(exp_rd));
    chk(!(rd_valid && q.size() == 0), "R2 valid with model empty", 32'(rd_valid), 0);
  end

  always @(negedge wr_clk) if (rst_n)
    chk(!(wr_ready && q.size() == DEPTH), "R3 ready with model full", 32'(wr_ready), 0);

  task automatic wr_word(input logic [17:0] d);
    @(negedge wr_clk); wr_valid = 1'b1; wr_data = d;
    @(posedge wr_clk); #1 wr_valid = 1'b0;
  endtask

  task automatic ld_off(input logic [17:0] d);
    @(negedge wr_clk); wr_valid = 1'b1; load_en = 1'b1; wr_data = d;
    @(posedge wr_clk); #1 wr_valid = 1'b0; load_en = 1'b0;
  endtask

  task automatic rd_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk); rd_ready = 1'b1;
      @(posedge rd_clk); #1 rd_ready = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic flags(input string req, input logic h, input logic ae, input logic af);
    chk(half_n == h, {req, " half_n"}, 32'(half_n), 32'(h));
    chk(aempty_n == ae, {req, " aempty_n"}, 32'(aempty_n), 32'(ae));
    chk(afull_n == af, {req, " afull_n"}, 32'(afull_n), 32'(af));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    #33 rst_n = 1'b1;
    @(negedge wr_clk);
    // R11 reset state
    chk(rd_valid == 1'b0, "R11 rd_valid", 32'(rd_valid), 0);
    chk(wr_ready == 1'b1, "R11 wr_ready", 32'(wr_ready), 1);
    chk(rd_data == '0, "R11 rd_data", 32'(rd_data), 0);
    flags("R11", 1'b1, 1'b0, 1'b1);

    // R2 latency, R7 default n=7
    wr_word(18'h10000);
    repeat (4) @(posedge rd_clk);
    #1 chk(rd_valid == 1'b1, "R2 valid after write", 32'(rd_valid), 1);
    for (int i = 1; i < 5; i++) wr_word(18'h10000 + 18'(i));
    settle();
    flags("R7 count5", 1'b1, 1'b0, 1'b1);
    for (int i = 5; i < 8; i++) wr_word(18'h10000 + 18'(i));
    settle();
    flags("R5 R7 count8", 1'b1, 1'b1, 1'b1);
    wr_word(18'h10008);
    settle();
    flags("R5 R6 count9", 1'b0, 1'b1, 1'b0);

    // R3 fill, offer while full
    for (int i = 9; i < DEPTH; i++) wr_word(18'h10000 + 18'(i));
    settle();
    chk(wr_ready == 1'b0, "R3 full", 32'(wr_ready), 0);
    wr_word(18'h3FFFF);
    rd_n(DEPTH);
    settle();
    chk(rd_valid == 1'b0, "R3 write while full dropped", 32'(rd_valid), 0);
    last_word = rd_data;
    chk(last_word == 18'h1000F, "R3 last word", 32'(last_word), 32'h1000F);

    // R4 pops while empty
    rd_n(3);
    settle();
    chk(rd_data == last_word, "R4 rd_data held", 32'(rd_data), 32'(last_word));
    chk(rd_valid == 1'b0, "R4 still empty", 32'(rd_valid), 0);

    // R8 load n=3 then m=12
    ld_off(18'h00003);
    ld_off(18'h0000C);
    settle();
    chk(rd_valid == 1'b0, "R8 loads not queued", 32'(rd_valid), 0);
    for (int i = 0; i < 3; i++) wr_word(18'h20000 + 18'(i));
    settle();
    flags("R8 count3", 1'b1, 1'b0, 1'b1);
    wr_word(18'h20003);
    settle();
    flags("R8 count4", 1'b1, 1'b1, 1'b0);

    // R9 cross-domain flag timing
    flag_mode = 1'b1;
    settle();
    flags("R9 mode1 count4", 1'b1, 1'b1, 1'b0);
    rd_n(1);
    settle();
    flags("R9 mode1 count3", 1'b1, 1'b0, 1'b1);
    flag_mode = 1'b0;
    rd_n(3);
    settle();

    // R1 streaming with irregular read stalls
    fork
      for (int i = 0; i < 40; i++) wr_word(18'(32'h2A5A5 + 32'(i * 977)));
      for (int i = 0; i < 120; i++) begin
        @(negedge rd_clk); rd_ready = 1'($urandom_range(0, 1));
      end
    join
    rd_ready = 1'b0;
    settle();
    while (rd_valid) begin
      rd_n(1);
      settle();
    end
    chk(q.size() == 0, "R1 all words delivered", 32'(q.size()), 0);
    chk(rd_valid == 1'b0, "R2 drained", 32'(rd_valid), 0);

    summary();
    $finish;
  end
endmodule